// File: doc/BRIEF.md
# Raster Timing Generator with Border Window

This block drives the scan of a video output. A horizontal counter runs through the clocks of a line, and a vertical counter runs through the lines of a field. From the two counts the block derives horizontal and vertical sync, a visible border region, an active picture window inside that region, the border colour, and the window-relative pixel coordinates for a downstream pixel fetch. Sync occupies the part of each line, and of each field, that lies outside the programmed border limits. This means the sync length is not a separate setting. It follows from the border start, the total and the border stop.

A host writes configuration words into a shadow bank through a simple write port. The running timing never sees those writes directly. The whole bank is copied into the active registers in a single cycle, when the vertical counter enters the retrace interval, and a one-cycle vertical-blank interrupt marks that cycle. A mode can therefore be changed without a torn frame.

Four mode options modify the output:
- Interlaced operation alternates a long field and a short field.
- Scan doubling repeats each source line.
- Horizontal pixel doubling halves the pixel rate.
- A blank bit paints the border colour over the whole visible screen.

Top module: `rast_timing_gen`

## Requirements
- R1: The size word (select 0) holds lines per field in bits [31:16] and clocks per line in bits [15:0]. The horizontal count runs 0 to clocks-1 and then wraps to 0 while the vertical count advances. The vertical count wraps to 0 after the last line of the field.
- R2: The horizontal border word (select 1) holds the border start in bits [31:16] and the border stop in bits [15:0]. hsync_o is high when the horizontal count is below the start or at or above the stop, so a line has start + total - stop sync clocks.
- R3: The vertical border word (select 2) uses the same start and stop layout. vsync_o is high on lines below its start or at or above its stop.
- R4: Inside both border spans, active_o is high where the horizontal count is at least the window horizontal start (select 3, bits [15:0]) and the vertical count is at least the window vertical start (select 4, bits [15:0]). The rest of the visible area is border: border_o is high there and colour_o carries the border colour (select 8, bits [23:0]). colour_o is 0 wherever border_o is low.
- R5: Bit 3 of the window configuration word (select 7) forces border_o high and active_o low over the whole visible area. Clearing the bit restores the window.
- R6: Bit 8 of the sync configuration word (select 5) enables video. When it is clear, hsync_o, vsync_o, active_o and border_o are all low. Bit 0 of the mode word (select 6) enables the display window. When that bit is clear, the window area is shown as border.
- R7: vblank_irq_o is high for exactly one cycle: the first cycle of the line whose number equals the vertical border stop. The shadow bank is copied into the active registers at the edge that begins that cycle. Writes have no effect on the outputs before such a cycle. Select codes 9 to 15 are ignored.
- R8: Bit 4 of the sync configuration word enables interlace. field_o toggles at each field end. Field 0 is the long field and has one line more than the programmed total. The window row reported on pix_y_o is 2 × row + field_o. With interlace off, field_o returns to 0 at the next field end.
- R9: Bit 1 of the mode word enables scan doubling. pix_y_o is then the window row divided by 2. Scan doubling is ignored while interlace is on.
- R10: Bit 0 of the window configuration word enables pixel doubling. pix_x_o is then the window column divided by 2, and otherwise it is the column itself. pix_x_o and pix_y_o are 0 whenever active_o is low.
- R11: During and after reset both counters and field_o are 0, vblank_irq_o is low, and the shadow and active banks both hold the parameter defaults. With those defaults, video and display are enabled and interlace, doubling and blank are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe into the shadow bank |
| wr_sel | input | 4 | Shadow register select (0 to 8) |
| wr_data | input | 32 | Shadow register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| active_o | output | 1 | Pixel lies in the active window |
| border_o | output | 1 | Pixel lies in the border region |
| colour_o | output | 24 | Border colour while border_o is high, else 0 |
| vblank_irq_o | output | 1 | One-cycle pulse at retrace entry and commit |
| field_o | output | 1 | Current field, 0 for the long field |
| pix_x_o | output | 16 | Window-relative pixel column |
| pix_y_o | output | 16 | Window-relative pixel row |

## Verification
The assertions rely on a host that programs at least two clocks per line, and a vertical border stop below the line total. Without the second condition the retrace is never reached and no commit can take place. They also rely on a host that never programs a line total of zero. The random stimulus draws every field from a fixed range chosen so that these conditions hold for any mix of old and new words. This matters because a commit can land in the middle of a reprogramming sequence. The mode bits, meanwhile, are drawn freely, so every combination of interlace, doubling, blank and the two enables is reached.

// File: rtl/rast_pkg.sv
package rast_pkg;
  localparam int CW   = 16;
  localparam int COLW = 24;
  localparam int SELW = 4;
  localparam int DW   = 32;

  localparam logic [SELW-1:0] SEL_SIZE   = 4'd0;
  localparam logic [SELW-1:0] SEL_HBRD   = 4'd1;
  localparam logic [SELW-1:0] SEL_VBRD   = 4'd2;
  localparam logic [SELW-1:0] SEL_WINH   = 4'd3;
  localparam logic [SELW-1:0] SEL_WINV   = 4'd4;
  localparam logic [SELW-1:0] SEL_SYNC   = 4'd5;
  localparam logic [SELW-1:0] SEL_MODE   = 4'd6;
  localparam logic [SELW-1:0] SEL_WCFG   = 4'd7;
  localparam logic [SELW-1:0] SEL_COLOUR = 4'd8;

  localparam int VIDEN_BIT  = 8;
  localparam int INTL_BIT   = 4;
  localparam int DISPEN_BIT = 0;
  localparam int DBL_BIT    = 1;
  localparam int LOWRES_BIT = 0;
  localparam int BLANK_BIT  = 3;

  typedef struct packed {
    logic [CW-1:0]   htot;
    logic [CW-1:0]   vtot;
    logic [CW-1:0]   hbstart;
    logic [CW-1:0]   hbstop;
    logic [CW-1:0]   vbstart;
    logic [CW-1:0]   vbstop;
    logic [CW-1:0]   winh;
    logic [CW-1:0]   winv;
    logic            vid_en;
    logic            intl;
    logic            disp_en;
    logic            dbl;
    logic            lowres;
    logic            blank;
    logic [COLW-1:0] colour;
  } rast_cfg_t;
endpackage

// File: rtl/rast_regs.sv
module rast_regs
  import rast_pkg::*;
#(
  parameter int DEF_HTOT    = 32,
  parameter int DEF_VTOT    = 16,
  parameter int DEF_HBSTART = 4,
  parameter int DEF_HBSTOP  = 28,
  parameter int DEF_VBSTART = 2,
  parameter int DEF_VBSTOP  = 14,
  parameter int DEF_WINH    = 8,
  parameter int DEF_WINV    = 4,
  parameter int DEF_COLOUR  = 24'h102030
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            commit_i,
  output rast_cfg_t       act_o
);
  localparam rast_cfg_t DEF_CFG = '{
    htot:    CW'(DEF_HTOT),    vtot:    CW'(DEF_VTOT),
    hbstart: CW'(DEF_HBSTART), hbstop:  CW'(DEF_HBSTOP),
    vbstart: CW'(DEF_VBSTART), vbstop:  CW'(DEF_VBSTOP),
    winh:    CW'(DEF_WINH),    winv:    CW'(DEF_WINV),
    vid_en:  1'b1, intl: 1'b0, disp_en: 1'b1, dbl: 1'b0,
    lowres:  1'b0, blank: 1'b0, colour: COLW'(DEF_COLOUR)
  };

  rast_cfg_t sh_q, sh_nxt, act_q, act_nxt;

  always_comb begin
    sh_nxt = sh_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_SIZE:   begin sh_nxt.vtot = wr_data[31:16]; sh_nxt.htot = wr_data[15:0]; end
        SEL_HBRD:   begin sh_nxt.hbstart = wr_data[31:16]; sh_nxt.hbstop = wr_data[15:0]; end
        SEL_VBRD:   begin sh_nxt.vbstart = wr_data[31:16]; sh_nxt.vbstop = wr_data[15:0]; end
        SEL_WINH:   sh_nxt.winh = wr_data[CW-1:0];
        SEL_WINV:   sh_nxt.winv = wr_data[CW-1:0];
        SEL_SYNC:   begin sh_nxt.vid_en = wr_data[VIDEN_BIT]; sh_nxt.intl = wr_data[INTL_BIT]; end
        SEL_MODE:   begin sh_nxt.disp_en = wr_data[DISPEN_BIT]; sh_nxt.dbl = wr_data[DBL_BIT]; end
        SEL_WCFG:   begin sh_nxt.lowres = wr_data[LOWRES_BIT]; sh_nxt.blank = wr_data[BLANK_BIT]; end
        SEL_COLOUR: sh_nxt.colour = wr_data[COLW-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    act_nxt = act_q;
    if (commit_i) act_nxt = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= DEF_CFG;
      act_q <= DEF_CFG;
    end else begin
      sh_q  <= sh_nxt;
      act_q <= act_nxt;
    end
  end

  assign act_o = act_q;

  // R7: active bank moves only on a commit edge
  assert_act_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(act_q));
endmodule

// File: rtl/rast_counters.sv
module rast_counters
  import rast_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  rast_cfg_t     act_i,
  output logic [CW-1:0] hcnt_o,
  output logic [CW-1:0] vcnt_o,
  output logic          field_o,
  output logic          irq_o,
  output logic          commit_o
);
  logic [CW-1:0] hcnt_q, hcnt_nxt, vcnt_q, vcnt_nxt;
  logic          field_q, field_nxt, irq_q, irq_nxt;
  logic          line_end, field_end;
  logic [CW:0]   last_line_cnt;

  always_comb begin
    line_end      = ({1'b0, hcnt_q} + 1'b1) >= {1'b0, act_i.htot};
    last_line_cnt = {1'b0, act_i.vtot} + {{CW{1'b0}}, (act_i.intl & ~field_q)};
    field_end     = ({1'b0, vcnt_q} + 1'b1) >= last_line_cnt;
    hcnt_nxt      = line_end ? '0 : hcnt_q + 1'b1;
    vcnt_nxt      = vcnt_q;
    field_nxt     = field_q;
    if (line_end) begin
      vcnt_nxt = field_end ? '0 : vcnt_q + 1'b1;
      if (field_end) field_nxt = act_i.intl ? ~field_q : 1'b0;
    end
    irq_nxt = line_end && (vcnt_nxt == act_i.vbstop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      field_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      hcnt_q  <= hcnt_nxt;
      vcnt_q  <= vcnt_nxt;
      field_q <= field_nxt;
      irq_q   <= irq_nxt;
    end
  end

  assign hcnt_o   = hcnt_q;
  assign vcnt_o   = vcnt_q;
  assign field_o  = field_q;
  assign irq_o    = irq_q;
  assign commit_o = irq_nxt;

  // R1: horizontal count stays inside the programmed line
  assert_hpos_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i.htot != '0) |-> (hcnt_q < act_i.htot));
  // R7: interrupt is a single-cycle pulse
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R7: interrupt lands on the first clock of a line
  assert_irq_linestart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (hcnt_q == '0));
  // R8: field flag changes only at the start of a field
  assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hcnt_q == '0 && vcnt_q == '0) |-> $stable(field_q));
endmodule

// File: rtl/rast_decode.sv
module rast_decode
  import rast_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  rast_cfg_t       act_i,
  input  logic [CW-1:0]   hcnt_i,
  input  logic [CW-1:0]   vcnt_i,
  input  logic            field_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            active_o,
  output logic            border_o,
  output logic [COLW-1:0] colour_o,
  output logic [CW-1:0]   pix_x_o,
  output logic [CW-1:0]   pix_y_o
);
  logic          hvis, vvis, vis, in_win, show;
  logic [CW-1:0] col, row;

  always_comb begin
    hvis     = (hcnt_i >= act_i.hbstart) && (hcnt_i < act_i.hbstop);
    vvis     = (vcnt_i >= act_i.vbstart) && (vcnt_i < act_i.vbstop);
    vis      = hvis && vvis;
    in_win   = (hcnt_i >= act_i.winh) && (vcnt_i >= act_i.winv);
    show     = act_i.disp_en && !act_i.blank;
    hsync_o  = act_i.vid_en && !hvis;
    vsync_o  = act_i.vid_en && !vvis;
    active_o = act_i.vid_en && vis && show && in_win;
    border_o = act_i.vid_en && vis && !active_o;
    colour_o = border_o ? act_i.colour : '0;
    col      = hcnt_i - act_i.winh;
    row      = vcnt_i - act_i.winv;
    pix_x_o  = '0;
    pix_y_o  = '0;
    if (active_o) begin
      pix_x_o = act_i.lowres ? (col >> 1) : col;
      if (act_i.intl)     pix_y_o = {row[CW-2:0], field_i};
      else if (act_i.dbl) pix_y_o = row >> 1;
      else                pix_y_o = row;
    end
  end

  // R4: window and border never overlap
  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_o && border_o));
  // R4: no picture during either sync
  assert_active_nosync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (!hsync_o && !vsync_o));
  // R5: blank suppresses the window
  assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_i.blank |-> !active_o);
  // R6: video disable silences every raster output
  assert_vid_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i.vid_en |-> (!hsync_o && !vsync_o && !border_o));
  // R10: coordinates are zero outside the window
  assert_pix_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (pix_x_o == '0 && pix_y_o == '0));
endmodule

// File: rtl/rast_timing_gen.sv
module rast_timing_gen
  import rast_pkg::*;
#(
  parameter int DEF_HTOT    = 32,
  parameter int DEF_VTOT    = 16,
  parameter int DEF_HBSTART = 4,
  parameter int DEF_HBSTOP  = 28,
  parameter int DEF_VBSTART = 2,
  parameter int DEF_VBSTOP  = 14,
  parameter int DEF_WINH    = 8,
  parameter int DEF_WINV    = 4,
  parameter int DEF_COLOUR  = 24'h102030
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        active_o,
  output logic        border_o,
  output logic [23:0] colour_o,
  output logic        vblank_irq_o,
  output logic        field_o,
  output logic [15:0] pix_x_o,
  output logic [15:0] pix_y_o
);
  rast_cfg_t     act;
  logic [CW-1:0] hcnt, vcnt;
  logic          field, commit;

  rast_regs #(
    .DEF_HTOT(DEF_HTOT), .DEF_VTOT(DEF_VTOT),
    .DEF_HBSTART(DEF_HBSTART), .DEF_HBSTOP(DEF_HBSTOP),
    .DEF_VBSTART(DEF_VBSTART), .DEF_VBSTOP(DEF_VBSTOP),
    .DEF_WINH(DEF_WINH), .DEF_WINV(DEF_WINV), .DEF_COLOUR(DEF_COLOUR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .commit_i(commit), .act_o(act)
  );

  rast_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .act_i(act), .hcnt_o(hcnt), .vcnt_o(vcnt),
    .field_o(field), .irq_o(vblank_irq_o), .commit_o(commit)
  );

  rast_decode u_dec (
    .clk(clk), .rst_n(rst_n), .act_i(act), .hcnt_i(hcnt), .vcnt_i(vcnt),
    .field_i(field), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .active_o(active_o), .border_o(border_o), .colour_o(colour_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
  );

  assign field_o = field;
endmodule

// File: tb/rast_timing_gen_bench.sv
module rast_timing_gen_bench;
  import rast_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        hsync_o, vsync_o, active_o, border_o, vblank_irq_o, field_o;
  logic [23:0] colour_o;
  logic [15:0] pix_x_o, pix_y_o;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;

  always #10 clk = ~clk;

  rast_timing_gen u_rast_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .active_o(active_o), .border_o(border_o),
    .colour_o(colour_o), .vblank_irq_o(vblank_irq_o), .field_o(field_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
  );

  // reference model state, built from the requirements
  int ms_htot, ms_vtot, ms_hbs, ms_hbe, ms_vbs, ms_vbe, ms_winh, ms_winv, ms_col;
  bit ms_vid, ms_intl, ms_disp, ms_dbl, ms_low, ms_blank;
  int ma_htot, ma_vtot, ma_hbs, ma_hbe, ma_vbs, ma_vbe, ma_winh, ma_winv, ma_col;
  bit ma_vid, ma_intl, ma_disp, ma_dbl, ma_low, ma_blank;
  int m_h, m_v;
  bit m_f, m_irq;
  int nh, nv;
  bit nf, nirq, le, ll;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_htot = 32; ms_vtot = 16; ms_hbs = 4; ms_hbe = 28; ms_vbs = 2; ms_vbe = 14;
      ms_winh = 8; ms_winv = 4; ms_col = 24'h102030;
      ms_vid = 1; ms_intl = 0; ms_disp = 1; ms_dbl = 0; ms_low = 0; ms_blank = 0;
      ma_htot = ms_htot; ma_vtot = ms_vtot; ma_hbs = ms_hbs; ma_hbe = ms_hbe;
      ma_vbs = ms_vbs; ma_vbe = ms_vbe; ma_winh = ms_winh; ma_winv = ms_winv;
      ma_col = ms_col; ma_vid = ms_vid; ma_intl = ms_intl; ma_disp = ms_disp;
      ma_dbl = ms_dbl; ma_low = ms_low; ma_blank = ms_blank;
      m_h = 0; m_v = 0; m_f = 0; m_irq = 0;
    end else begin
      le = (m_h + 1 >= ma_htot);
      ll = (m_v + 1 >= ma_vtot + ((ma_intl && !m_f) ? 1 : 0));
      nh = le ? 0 : m_h + 1;
      nv = le ? (ll ? 0 : m_v + 1) : m_v;
      nf = (le && ll) ? (ma_intl ? !m_f : 1'b0) : m_f;
      nirq = le && (nv == ma_vbe);
      if (nirq) begin
        ma_htot = ms_htot; ma_vtot = ms_vtot; ma_hbs = ms_hbs; ma_hbe = ms_hbe;
        ma_vbs = ms_vbs; ma_vbe = ms_vbe; ma_winh = ms_winh; ma_winv = ms_winv;
        ma_col = ms_col; ma_vid = ms_vid; ma_intl = ms_intl; ma_disp = ms_disp;
        ma_dbl = ms_dbl; ma_low = ms_low; ma_blank = ms_blank;
      end
      if (wr_en) begin
        case (wr_sel)
          4'd0: begin ms_vtot = int'(wr_data[31:16]); ms_htot = int'(wr_data[15:0]); end
          4'd1: begin ms_hbs = int'(wr_data[31:16]); ms_hbe = int'(wr_data[15:0]); end
          4'd2: begin ms_vbs = int'(wr_data[31:16]); ms_vbe = int'(wr_data[15:0]); end
          4'd3: ms_winh = int'(wr_data[15:0]);
          4'd4: ms_winv = int'(wr_data[15:0]);
          4'd5: begin ms_vid = wr_data[8]; ms_intl = wr_data[4]; end
          4'd6: begin ms_disp = wr_data[0]; ms_dbl = wr_data[1]; end
          4'd7: begin ms_low = wr_data[0]; ms_blank = wr_data[3]; end
          4'd8: ms_col = int'(wr_data[23:0]);
          default: ;
        endcase
      end
      m_h = nh; m_v = nv; m_f = nf; m_irq = nirq;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin : cmp
      bit hv, vv, e_hs, e_vs, e_act, e_brd;
      int e_col, e_px, e_py, row, cl;
      hv = (m_h >= ma_hbs) && (m_h < ma_hbe);
      vv = (m_v >= ma_vbs) && (m_v < ma_vbe);
      e_hs = ma_vid && !hv;
      e_vs = ma_vid && !vv;
      e_act = ma_vid && hv && vv && ma_disp && !ma_blank && (m_h >= ma_winh) && (m_v >= ma_winv);
      e_brd = ma_vid && hv && vv && !e_act;
      e_col = e_brd ? ma_col : 0;
      cl = m_h - ma_winh;
      row = m_v - ma_winv;
      e_px = 0; e_py = 0;
      if (e_act) begin
        e_px = ma_low ? cl / 2 : cl;
        if (ma_intl) e_py = (row * 2 + int'(m_f)) & 16'hffff;
        else if (ma_dbl) e_py = row / 2;
        else e_py = row;
      end
      chk(hsync_o == e_hs, "R1 R2 hsync", hsync_o, e_hs);
      chk(vsync_o == e_vs, "R1 R3 vsync", vsync_o, e_vs);
      chk(active_o == e_act, "R4 R5 R6 active", active_o, e_act);
      chk(border_o == e_brd, "R4 R5 R6 border", border_o, e_brd);
      chk(colour_o == 24'(e_col), "R4 R7 colour", colour_o, e_col);
      chk(vblank_irq_o == m_irq, "R7 irq", vblank_irq_o, m_irq);
      chk(field_o == m_f, "R8 field", field_o, m_f);
      chk(pix_x_o == 16'(e_px), "R10 pix_x", pix_x_o, e_px);
      chk(pix_y_o == 16'(e_py), "R8 R9 pix_y", pix_y_o, e_py);
    end
  end

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_modes(input bit vid, input bit intl, input bit disp, input bit dbl,
                           input bit low, input bit blank);
    wr(5, (32'(vid) << 8) | (32'(intl) << 4));
    wr(6, 32'(disp) | (32'(dbl) << 1));
    wr(7, 32'(low) | (32'(blank) << 3));
  endtask

  task automatic rand_geom();
    int ht, vt;
    ht = 20 + int'($urandom % 21);
    vt = 15 + int'($urandom % 6);
    wr(0, {16'(vt), 16'(ht)});
    wr(1, {16'(1 + $urandom % 5), 16'(12 + $urandom % 9)});
    wr(2, {16'(1 + $urandom % 3), 16'(8 + $urandom % 6)});
    wr(3, 32'(6 + $urandom % 6));
    wr(4, 32'(4 + $urandom % 4));
    wr(8, $urandom & 32'h00ff_ffff);
  endtask

  // R2: measure one sync line directly at the ports with the defaults
  task automatic measure_hsync();
    int lo, hi;
    bit prev;
    prev = hsync_o;
    forever begin
      @(negedge clk);
      if (prev && !hsync_o) break;
      prev = hsync_o;
    end
    lo = 0;
    while (!hsync_o) begin lo++; @(negedge clk); end
    hi = 0;
    while (hsync_o) begin hi++; @(negedge clk); end
    chk(lo == 24, "R2 visible clocks per line", lo, 24);
    chk(hi == 8, "R2 sync clocks start+total-stop", hi, 8);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state (count 0 lies before the border start -> both syncs high)
    chk(vblank_irq_o == 1'b0, "R11 irq in reset", vblank_irq_o, 0);
    chk(field_o == 1'b0, "R11 field in reset", field_o, 0);
    chk(hsync_o == 1'b1, "R11 hsync in reset", hsync_o, 1);
    chk(vsync_o == 1'b1, "R11 vsync in reset", vsync_o, 1);
    chk(pix_x_o == 16'd0, "R11 pix_x in reset", pix_x_o, 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    measure_hsync();
    // R7: ignored select codes and uncommitted writes
    wr(12, 32'hffff_ffff);
    wr(8, 32'h00abcdef);
    repeat (1500) @(negedge clk);
    // R8: interlace
    set_modes(1, 1, 1, 0, 0, 0);
    repeat (3000) @(negedge clk);
    // R9: scan doubling, and doubling with interlace
    set_modes(1, 0, 1, 1, 0, 0);
    repeat (2000) @(negedge clk);
    set_modes(1, 1, 1, 1, 1, 0);
    repeat (2000) @(negedge clk);
    // R10: pixel doubling
    set_modes(1, 0, 1, 0, 1, 0);
    repeat (1500) @(negedge clk);
    // R5: blank, then restore
    set_modes(1, 0, 1, 0, 0, 1);
    repeat (1500) @(negedge clk);
    set_modes(1, 0, 1, 0, 0, 0);
    repeat (1500) @(negedge clk);
    // R6: video off, display off
    set_modes(0, 0, 1, 0, 0, 0);
    repeat (1500) @(negedge clk);
    set_modes(1, 0, 0, 0, 0, 0);
    repeat (1500) @(negedge clk);
    // random geometry and modes
    for (int i = 0; i < 120; i++) begin
      if ($urandom % 2 == 0) rand_geom();
      set_modes(($urandom % 8) != 0, $urandom % 2, ($urandom % 4) != 0,
                $urandom % 2, $urandom % 2, ($urandom % 6) == 0);
      repeat (200 + $urandom % 600) @(negedge clk);
    end
    chk_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule